// File: doc/BRIEF.md
# Serial Write-Only Configuration Port

This block lets a host load a small bank of nine 8-bit configuration registers over a three-wire serial link made of an active-low chip select, a serial clock and a serial data line. Each transaction is a single 16-bit write word. The block oversamples all three link wires with its own system clock, which must run at least eight times faster than the serial clock. It assembles each word and applies it to the register bank when chip select returns high.

The bank holds these registers in order: a reference divider, the low and high bytes of the feedback divider, two output divider codes, two control registers, a status slot and a spare register. The status slot is not stored. It always mirrors an input port, and serial writes to it are ignored. There are two ways to restore every register to its reset value: an active-high master reset input, or a single self-clear bit inside control register 6. The whole bank is presented as one flat bus, with register i on bits [8*i+7 : 8*i].

Top module: `serial_cfg_port`

## Requirements
- R1: After the active-low system reset, every stored register reads 8'h00, except register 5, which reads 8'h60. Byte 7 of the bus equals `statusIn`.
- R2: A word is 16 bits sent MSB first. Bit 15 is a mode bit and must be 0. Bits 14:8 are the register address, with bit 14 as the MSB. Bits 7:0 are the data, with bit 7 as the MSB. A valid word writes its data to the addressed register, and the bus shows the new value no later than 8 system clocks after chip select rises.
- R3: A bit is taken on each rising serial-clock edge while chip select is low. Clock and data activity while chip select is high leaves the bank unchanged.
- R4: A word whose bit 15 is 1 is discarded.
- R5: A word whose address is above 8 is discarded.
- R6: A word is discarded if chip select rises after fewer than 16 or more than 16 rising clock edges.
- R7: A word addressed to register 7 is discarded. Byte 7 of the bus always follows `statusIn`.
- R8: While `masterRst` is high at a system clock edge, every stored register returns to its R1 value. This holds even when a word completes in that same cycle; the reset wins.
- R9: A valid word to register 6 with data bit 4 set returns every stored register, including register 6, to its R1 value. A word to register 6 with bit 4 clear is stored normally.
- R10: Words separated by chip select high for two serial-clock periods are each applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| masterRst | input | 1 | Synchronous active-high reset of the register bank |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; must be low when csN falls |
| sdi | input | 1 | Serial data, MSB first |
| statusIn | input | 8 | Value presented in the status slot (register 7) |
| cfgBus | output | 72 | Register bank, register i on bits 8*i+7:8*i |

## Verification
The master reset and the completion of a word can land on the same system clock edge. In that case the bank must end at its defaults and must not hold the word's data. The bench provokes this collision by counting the two synchronizer stages after it raises chip select, then asserting `masterRst` for exactly the edge at which the write strobe is presented. It judges the outcome by comparing the whole bus with the default image. A behavioural model, which applies or discards each word from its bit count, mode bit and address, is also compared with the bus on every clock once the settle window after a chip-select rise has passed.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int NUM_REGS    = 9;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 7;
  localparam int FRAME_W     = 16;
  localparam int STATUS_IDX  = 7;
  localparam int SELFRST_REG = 6;
  localparam int SELFRST_BIT = 4;
  localparam int CTRL5_IDX   = 5;
  localparam logic [REG_W-1:0] CTRL5_DEFAULT = 8'h60;
  localparam int BUS_W       = NUM_REGS * REG_W;
  localparam int IDX_W       = $clog2(NUM_REGS);

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } wrStrobe_t;

  function automatic logic [REG_W-1:0] regDefault(input int idx);
    return (idx == CTRL5_IDX) ? CTRL5_DEFAULT : '0;
  endfunction

  function automatic logic [BUS_W-1:0] defaultBus();
    logic [BUS_W-1:0] b;
    for (int i = 0; i < NUM_REGS; i++) b[i*REG_W +: REG_W] = regDefault(i);
    return b;
  endfunction

  function automatic logic [BUS_W-1:0] storedMask();
    logic [BUS_W-1:0] m;
    m = '1;
    m[STATUS_IDX*REG_W +: REG_W] = '0;
    return m;
  endfunction
endpackage

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sercfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      sdi,
  output wrStrobe_t strb
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic csS, sclkS, sdiS, csD, sclkD;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic sclkRise, csRise, frameOk;
  logic [ADDR_W-1:0]  frameAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      csD      <= 1'b1;
      sclkD    <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      csD      <= csS;
      sclkD    <= sclkS;
    end
  end

  assign csS      = csPipe[SYNC_STAGES-1];
  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign sdiS     = sdiPipe[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkD;
  assign csRise   = csS & ~csD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (csS) begin
      bitCnt <= '0;
    end else if (sclkRise) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], sdiS};
      if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign frameAddr = shiftReg[FRAME_W-2 -: ADDR_W];
  assign frameOk   = (bitCnt == CNT_W'(FRAME_W)) && !shiftReg[FRAME_W-1]
                   && (int'(frameAddr) <= NUM_REGS - 1)
                   && (int'(frameAddr) != STATUS_IDX);

  always_comb begin
    strb.wrEn = csRise & frameOk;
    strb.addr = frameAddr;
    strb.data = shiftReg[REG_W-1:0];
  end

  // R6: a boundary reached with a wrong bit count never produces a write
  assert_short_long_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && bitCnt != CNT_W'(FRAME_W)) |-> !strb.wrEn);
  // R3: writes only appear on the cycle chip select has returned high
  assert_strobe_on_boundary_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (csS && $past(!csS)));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import sercfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterRst,
  input  wrStrobe_t        strb,
  input  logic [REG_W-1:0] statusIn,
  output logic [BUS_W-1:0] cfgBus
);
  localparam logic [BUS_W-1:0] DEF_BUS  = defaultBus();
  localparam logic [BUS_W-1:0] KEEP_MSK = storedMask();

  logic [REG_W-1:0] regs [NUM_REGS];
  logic [IDX_W-1:0] addrIdx;
  logic             selfRst;

  assign addrIdx = strb.addr[IDX_W-1:0];
  assign selfRst = strb.wrEn && (int'(strb.addr) == SELFRST_REG) && strb.data[SELFRST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= regDefault(i);
    end else if (masterRst || selfRst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= regDefault(i);
    end else if (strb.wrEn) begin
      regs[addrIdx] <= strb.data;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    if (g == STATUS_IDX) begin : gStatus
      assign cfgBus[g*REG_W +: REG_W] = statusIn;
    end else begin : gStored
      assign cfgBus[g*REG_W +: REG_W] = regs[g];
    end
  end

  // R8: master reset restores the default image on the following edge
  assert_master_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    masterRst |=> (((cfgBus ^ DEF_BUS) & KEEP_MSK) == '0));
  // R3: without a strobe or reset the stored image does not move
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrEn && !masterRst) |=> $stable(cfgBus & KEEP_MSK));
  // R2: a plain write lands in the addressed register
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !masterRst && !selfRst) |=> (regs[$past(addrIdx)] == $past(strb.data)));
  // R9: self-clear bit restores defaults
  assert_self_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    selfRst |=> (((cfgBus ^ DEF_BUS) & KEEP_MSK) == '0));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import sercfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterRst,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdi,
  input  logic [REG_W-1:0] statusIn,
  output logic [BUS_W-1:0] cfgBus
);
  wrStrobe_t strb;

  serial_frame_rx #(.SYNC_STAGES(2)) uRx (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .strb(strb)
  );

  cfg_reg_bank uBank (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .strb(strb),
    .statusIn(statusIn), .cfgBus(cfgBus)
  );
endmodule

// File: tb/sim_serial_cfg_port.sv
module sim_serial_cfg_port;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, masterRst, csN, sclk, sdi;
  logic [7:0]  statusIn;
  logic [71:0] cfgBus;

  serial_cfg_port u0 (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .csN(csN), .sclk(sclk),
    .sdi(sdi), .statusIn(statusIn), .cfgBus(cfgBus)
  );

  int nChk = 0, nFail = 0, monErr = 0, settle = 20;
  bit done = 0;
  logic [7:0] expR [9];

  function automatic logic [71:0] modelBus();
    logic [71:0] b;
    for (int i = 0; i < 9; i++) b[i*8 +: 8] = (i == 7) ? statusIn : expR[i];
    return b;
  endfunction

  task automatic modelDefaults();
    for (int i = 0; i < 9; i++) expR[i] = 8'h00;
    expR[5] = 8'h60;
  endtask

  task automatic modelApply(input logic [15:0] w, input int n);
    if (n == 16 && !w[15] && w[14:8] <= 7'd8 && w[14:8] != 7'd7) begin
      if (w[14:8] == 7'd6 && w[4]) modelDefaults();
      else expR[w[11:8]] = w[7:0];
    end
  endtask

  task automatic halfBit();
    repeat (5) @(negedge clk);
  endtask

  task automatic shiftBits(input logic [15:0] w, input int n);
    @(negedge clk); csN = 1'b0;
    halfBit();
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      halfBit(); sclk = 1'b1;
      halfBit(); sclk = 1'b0;
    end
  endtask

  task automatic raiseCs();
    @(negedge clk); csN = 1'b1; settle = 10;
  endtask

  task automatic frame(input logic [15:0] w, input int n);
    shiftBits(w, n); raiseCs(); modelApply(w, n);
    repeat (25) @(negedge clk);
  endtask

  task automatic check(input string tag, input string what);
    nChk++;
    if (cfgBus !== modelBus()) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, cfgBus, modelBus());
    end
  endtask

  always @(negedge clk) begin
    if (settle > 0) settle--;
    else if (rstN && cfgBus !== modelBus()) monErr++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; masterRst = 0; csN = 1; sclk = 0; sdi = 0; statusIn = 8'hA5;
    modelDefaults();
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    check("R1", "reset image");

    frame(16'h0012, 16); check("R2", "reg0 write");
    frame(16'h0134, 16); frame(16'h08C3, 16); check("R2", "reg1 and reg8 write");
    frame(16'h050F, 16); frame(16'h03AA, 16); check("R2", "reg5 and reg3 alternating data");

    for (int i = 0; i < 10; i++) begin
      sdi = i[0]; halfBit(); sclk = 1'b1; halfBit(); sclk = 1'b0;
    end
    repeat (10) @(negedge clk);
    check("R3", "activity with cs high");

    frame(16'h8155, 16); check("R4", "mode bit set");
    frame({1'b0, 7'd9, 8'hEE}, 16); frame({1'b0, 7'd127, 8'h11}, 16);
    check("R5", "address above 8");
    frame(16'h0266, 15); check("R6", "15-bit word");
    frame(16'h0266, 17); check("R6", "17-bit word");

    frame(16'h07FF, 16); statusIn = 8'h3C; settle = 3;
    repeat (3) @(negedge clk); check("R7", "status slot write and passthrough");

    shiftBits(16'h0421, 16); raiseCs(); modelApply(16'h0421, 16);
    repeat (20) @(negedge clk);
    shiftBits(16'h0222, 16); raiseCs(); modelApply(16'h0222, 16);
    repeat (25) @(negedge clk);
    check("R10", "back-to-back words");

    frame(16'h062F, 16); check("R9", "reg6 bit4 clear stored");
    frame(16'h0610, 16); check("R9", "reg6 bit4 set clears bank");

    frame(16'h0155, 16); frame(16'h0377, 16);
    @(negedge clk); masterRst = 1'b1; settle = 5;
    @(negedge clk); masterRst = 1'b0; modelDefaults();
    repeat (3) @(negedge clk); check("R8", "master reset");

    frame(16'h0499, 16);
    shiftBits(16'h0277, 16);
    @(negedge clk); csN = 1'b1; settle = 10;
    @(posedge clk); @(posedge clk);
    @(negedge clk); masterRst = 1'b1;
    @(negedge clk); masterRst = 1'b0; modelDefaults();
    repeat (20) @(negedge clk);
    check("R8", "reset same cycle as word commit");

    nChk++;
    if (monErr != 0) begin
      nFail++;
      $display("FAIL R2 per-clock model: actual %0d mismatches expected 0", monErr);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule